// File: doc/BRIEF.md
# 64b/66b Block Codec

This block sits between a MAC-side word interface and a serial-side block interface. On the transmit side it takes one 64-bit word per clock, together with eight flags that mark which bytes are control characters. It turns that word into a 66-bit block: a 2-bit sync header followed by a 64-bit payload. On the receive side it takes one 66-bit block per clock and turns it back into 64 data bits and eight control flags. Each direction has its own small sequencing state machine. An out-of-order or unencodable input is not passed on; it is replaced by an error block on transmit and by error characters on receive.

The receiver also takes a high-bit-error-rate status from an external monitor. While that status is raised, every received block is discarded. For link testing, the transmitter can deliberately spoil the sync header of the blocks it sends. Every such event is reported on a 3-bit error code that travels with the block. Build parameters select whether the encoder, the decoder and the header-spoiling feature exist at all. Both directions take exactly one registered cycle.

Byte lane i is bits 8i+7:8i of a word, and control flag i belongs to lane i. The character codes are idle 0x07, start 0xFB, terminate 0xFD and error 0xFE. In a block, bits 65:64 hold the sync header and bits 7:0 hold the block type.

Top module: `blk66_codec`

## Requirements
- R1: A transmit word whose eight control flags are all zero appears on the next cycle as a block with header 2'b01 and the word unchanged as payload.
- R2: Control words on transmit give header 2'b10 and are encoded as follows:
  - A word of eight idle bytes with all flags set gives type 0x1E and zero in bits 63:8.
  - A word with flags 0x01 and 0xFB in lane 0 gives type 0x78, and the lanes 1..7 bytes are kept in bits 63:8.
  - A terminate in lane k has data in lanes below k, 0xFD in lane k and idles above k, with flags set from bit k upward. Its type is 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0..7. The lane 0..k-1 bytes move to payload bytes 1..k, and the payload is zero above them.
- R3: The transmit sequencer flags data or terminate words that arrive while outside a packet, and a start word that arrives inside a packet. Each such word becomes an error block: header 2'b10, type 0x1E and eight 7-bit codes 0x1E in bits 63:8. Error code bit 0 is set for it. Error blocks continue until an idle or start word arrives.
- R4: A transmit word that matches none of the R1/R2 patterns becomes the R3 error block, with error code bit 1 set, and also moves the sequencer to its error state.
- R5: While the header-corrupt input is high, the outgoing header becomes 2'b00 for a data block or 2'b11 for a control block, and error code bit 2 is set. The payload is unchanged.
- R6: On receive, valid blocks of the R1/R2 kinds are decoded back to the same word and control flags that would have produced them.
- R7: A received header of 2'b00 or 2'b11, or a control block of an unknown type, yields eight 0xFE bytes, all control flags set and the receive error output high.
- R8: The receive sequencer applies the R3 ordering rules. It outputs R7 error characters for every out-of-order block until an idle or start block arrives.
- R9: While the high-error-rate input is asserted, the receiver outputs R7 error characters whatever the block. After the input is released it keeps doing so until an idle or start block arrives.
- R10: Reset is synchronous. During reset the transmit output is the idle block with error code 0, and the receive output is eight idle bytes with all flags set and no error. Both sequencers start outside a packet, so a data word as the first input is an ordering error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 64 | Transmit word, eight byte lanes |
| tx_ctrl | input | 8 | Per-lane control flags for tx_data |
| tx_hdr_corrupt | input | 1 | Spoil the sync header of this word's block |
| tx_blk | output | 66 | Encoded block, header in bits 65:64 |
| tx_err | output | 3 | Error code: bit 0 ordering, bit 1 pattern, bit 2 header spoiled |
| rx_blk | input | 66 | Received block, header in bits 65:64 |
| rx_ber_high | input | 1 | High bit-error-rate status from an external monitor |
| rx_data | output | 64 | Decoded word |
| rx_ctrl | output | 8 | Decoded per-lane control flags |
| rx_err | output | 1 | High when the decoded word is substituted error characters |

## Verification
On transmit, header spoiling and ordering-error substitution can act on the same word. To provoke this, the bench drives a data word with the corrupt input high while the sequencer is outside a packet. The expected block is the error payload under a 2'b11 header, with error code 3'b101. This shows that substitution happens first and spoiling is applied on top of the result. On receive, the bench raises the high-error-rate input during an otherwise legal packet, then releases it on a data block. It expects error characters until the next idle or start block.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

    localparam int LANES      = 8;
    localparam int LANE_W     = 8;
    localparam int WORD_W     = LANES * LANE_W;
    localparam int HDR_W      = 2;
    localparam int BLK_W      = HDR_W + WORD_W;
    localparam int CODE_W     = 7;
    localparam int LANE_IDX_W = $clog2(LANES);

    localparam int ERR_W   = 3;
    localparam int ERR_SEQ = 0;
    localparam int ERR_PAT = 1;
    localparam int ERR_INJ = 2;

    localparam logic [HDR_W-1:0]  HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0]  HDR_CTRL = 2'b10;

    localparam logic [LANE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [LANE_W-1:0] CH_START = 8'hFB;
    localparam logic [LANE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [LANE_W-1:0] CH_ERR   = 8'hFE;

    localparam logic [LANE_W-1:0] BT_IDLE  = 8'h1E;
    localparam logic [LANE_W-1:0] BT_START = 8'h78;
    localparam logic [CODE_W-1:0] CODE_ERR = 7'h1E;

    typedef enum logic [2:0] {K_DATA, K_IDLE, K_START, K_TERM, K_BAD} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_DATA, S_ERR} seq_e;

    typedef struct packed {
        kind_e                 kind;
        logic [LANE_IDX_W-1:0] lane;
    } cls_t;

    function automatic logic [LANE_W-1:0] term_type(input logic [LANE_IDX_W-1:0] k);
        logic [LANE_W-1:0] t;
        case (k)
            3'd0:    t = 8'h87;
            3'd1:    t = 8'h99;
            3'd2:    t = 8'hAA;
            3'd3:    t = 8'hB4;
            3'd4:    t = 8'hCC;
            3'd5:    t = 8'hD2;
            3'd6:    t = 8'hE1;
            default: t = 8'hFF;
        endcase
        return t;
    endfunction

    function automatic logic [LANES-1:0] term_mask(input logic [LANE_IDX_W-1:0] k);
        logic [LANES-1:0] m;
        m = '1;
        return m << k;
    endfunction

    function automatic logic [WORD_W-1:0] idle_payload();
        return {{(WORD_W-LANE_W){1'b0}}, BT_IDLE};
    endfunction

    function automatic logic [WORD_W-1:0] err_payload();
        return {{LANES{CODE_ERR}}, BT_IDLE};
    endfunction

    function automatic logic [WORD_W-1:0] fill_word(input logic [LANE_W-1:0] ch);
        return {LANES{ch}};
    endfunction

endpackage

// File: rtl/blk66_seq_fsm.sv
module blk66_seq_fsm
    import blk66_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  kind_e kind_i,
    input  logic  force_err_i,
    output logic  legal_o
);

    typedef struct packed {
        seq_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d   = fsm_q;
        legal_o = 1'b0;
        if (force_err_i || kind_i == K_BAD) begin
            fsm_d.st = S_ERR;
        end else begin
            case (fsm_q.st)
                S_IDLE: begin
                    case (kind_i)
                        K_IDLE:  begin legal_o = 1'b1; fsm_d.st = S_IDLE; end
                        K_START: begin legal_o = 1'b1; fsm_d.st = S_DATA; end
                        default: fsm_d.st = S_ERR;
                    endcase
                end
                S_DATA: begin
                    case (kind_i)
                        K_DATA:  begin legal_o = 1'b1; fsm_d.st = S_DATA; end
                        K_TERM:  begin legal_o = 1'b1; fsm_d.st = S_IDLE; end
                        K_IDLE:  begin legal_o = 1'b1; fsm_d.st = S_IDLE; end
                        default: fsm_d.st = S_ERR;
                    endcase
                end
                default: begin
                    case (kind_i)
                        K_IDLE:  begin legal_o = 1'b1; fsm_d.st = S_IDLE; end
                        K_START: begin legal_o = 1'b1; fsm_d.st = S_DATA; end
                        default: fsm_d.st = S_ERR;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q.st <= S_IDLE;
        else     fsm_q    <= fsm_d;
    end

endmodule

// File: rtl/blk66_tx_enc.sv
module blk66_tx_enc
    import blk66_pkg::*;
#(
    parameter bit HDR_INJ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_i,
    input  logic [LANES-1:0]  ctrl_i,
    input  logic              corrupt_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [ERR_W-1:0]  err_o
);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [ERR_W-1:0] err;
    } tx_out_t;

    cls_t              cls;
    logic [HDR_W-1:0]  enc_hdr;
    logic [WORD_W-1:0] enc_pay;
    logic              legal;
    tx_out_t           out_d, out_q;

    always_comb begin : classify
        logic all_idle;
        logic tail_ok;
        cls      = '{kind: K_BAD, lane: '0};
        all_idle = 1'b1;
        tail_ok  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (data_i[i*LANE_W +: LANE_W] != CH_IDLE) all_idle = 1'b0;
        end
        if (ctrl_i == '0) begin
            cls.kind = K_DATA;
        end else if ((&ctrl_i) && all_idle) begin
            cls.kind = K_IDLE;
        end else if (ctrl_i == LANES'(1) && data_i[LANE_W-1:0] == CH_START) begin
            cls.kind = K_START;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                tail_ok = (ctrl_i == term_mask(LANE_IDX_W'(k))) &&
                          (data_i[k*LANE_W +: LANE_W] == CH_TERM);
                for (int j = k + 1; j < LANES; j++) begin
                    if (data_i[j*LANE_W +: LANE_W] != CH_IDLE) tail_ok = 1'b0;
                end
                if (tail_ok) begin
                    cls.kind = K_TERM;
                    cls.lane = LANE_IDX_W'(k);
                end
            end
        end
    end

    always_comb begin : encode
        logic [WORD_W-1:0] low;
        enc_hdr = HDR_CTRL;
        enc_pay = idle_payload();
        low     = '0;
        case (cls.kind)
            K_DATA: begin
                enc_hdr = HDR_DATA;
                enc_pay = data_i;
            end
            K_START: enc_pay = {data_i[WORD_W-1:LANE_W], BT_START};
            K_TERM: begin
                low     = data_i & ((WORD_W'(1) << (LANE_W * int'(cls.lane))) - WORD_W'(1));
                enc_pay = {low[WORD_W-LANE_W-1:0], term_type(cls.lane)};
            end
            default: ;
        endcase
    end

    blk66_seq_fsm u_seq (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (cls.kind),
        .force_err_i (1'b0),
        .legal_o     (legal)
    );

    always_comb begin : next_out
        out_d.blk          = legal ? {enc_hdr, enc_pay} : {HDR_CTRL, err_payload()};
        out_d.err          = '0;
        out_d.err[ERR_SEQ] = !legal && (cls.kind != K_BAD);
        out_d.err[ERR_PAT] = (cls.kind == K_BAD);
        if (HDR_INJ_EN && corrupt_i) begin
            out_d.blk[BLK_W-1 -: HDR_W] = {HDR_W{out_d.blk[BLK_W-1]}};
            out_d.err[ERR_INJ]          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.blk <= {HDR_CTRL, idle_payload()};
            out_q.err <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign blk_o = out_q.blk;
    assign err_o = out_q.err;

endmodule

// File: rtl/blk66_rx_dec.sv
module blk66_rx_dec
    import blk66_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              ber_high_i,
    output logic [WORD_W-1:0] data_o,
    output logic [LANES-1:0]  ctrl_o,
    output logic              err_o
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  ctrl;
        logic              err;
    } rx_out_t;

    logic [HDR_W-1:0]  hdr;
    logic [WORD_W-1:0] pay;
    logic [LANE_W-1:0] btype;
    cls_t              cls;
    logic [WORD_W-1:0] dec_data;
    logic [LANES-1:0]  dec_ctrl;
    logic              legal;
    rx_out_t           out_d, out_q;

    assign hdr   = blk_i[BLK_W-1 -: HDR_W];
    assign pay   = blk_i[WORD_W-1:0];
    assign btype = pay[LANE_W-1:0];

    always_comb begin : classify
        cls = '{kind: K_BAD, lane: '0};
        if (hdr == HDR_DATA) begin
            cls.kind = K_DATA;
        end else if (hdr == HDR_CTRL) begin
            if (btype == BT_IDLE && pay[WORD_W-1:LANE_W] == '0) begin
                cls.kind = K_IDLE;
            end else if (btype == BT_START) begin
                cls.kind = K_START;
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (btype == term_type(LANE_IDX_W'(k))) begin
                        cls.kind = K_TERM;
                        cls.lane = LANE_IDX_W'(k);
                    end
                end
            end
        end
    end

    always_comb begin : decode
        logic [WORD_W-1:0] shifted;
        shifted  = pay >> LANE_W;
        dec_data = fill_word(CH_IDLE);
        dec_ctrl = '1;
        case (cls.kind)
            K_DATA: begin
                dec_data = pay;
                dec_ctrl = '0;
            end
            K_START: begin
                dec_data = {pay[WORD_W-1:LANE_W], CH_START};
                dec_ctrl = LANES'(1);
            end
            K_TERM: begin
                for (int i = 0; i < LANES; i++) begin
                    if (LANE_IDX_W'(i) < cls.lane)
                        dec_data[i*LANE_W +: LANE_W] = shifted[i*LANE_W +: LANE_W];
                    else if (LANE_IDX_W'(i) == cls.lane)
                        dec_data[i*LANE_W +: LANE_W] = CH_TERM;
                    else
                        dec_data[i*LANE_W +: LANE_W] = CH_IDLE;
                end
                dec_ctrl = term_mask(cls.lane);
            end
            default: ;
        endcase
    end

    blk66_seq_fsm u_seq (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (cls.kind),
        .force_err_i (ber_high_i),
        .legal_o     (legal)
    );

    always_comb begin : next_out
        if (legal) begin
            out_d.data = dec_data;
            out_d.ctrl = dec_ctrl;
            out_d.err  = 1'b0;
        end else begin
            out_d.data = fill_word(CH_ERR);
            out_d.ctrl = '1;
            out_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.data <= fill_word(CH_IDLE);
            out_q.ctrl <= '1;
            out_q.err  <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_o = out_q.data;
    assign ctrl_o = out_q.ctrl;
    assign err_o  = out_q.err;

endmodule

// File: rtl/blk66_codec.sv
module blk66_codec
    import blk66_pkg::*;
#(
    parameter bit TX_ENC_EN  = 1'b1,
    parameter bit RX_DEC_EN  = 1'b1,
    parameter bit HDR_INJ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [LANES-1:0]  tx_ctrl,
    input  logic              tx_hdr_corrupt,
    output logic [BLK_W-1:0]  tx_blk,
    output logic [ERR_W-1:0]  tx_err,
    input  logic [BLK_W-1:0]  rx_blk,
    input  logic              rx_ber_high,
    output logic [WORD_W-1:0] rx_data,
    output logic [LANES-1:0]  rx_ctrl,
    output logic              rx_err
);

    generate
        if (TX_ENC_EN) begin : g_tx
            blk66_tx_enc #(.HDR_INJ_EN(HDR_INJ_EN)) u_tx (
                .clk       (clk),
                .rst       (rst),
                .data_i    (tx_data),
                .ctrl_i    (tx_ctrl),
                .corrupt_i (tx_hdr_corrupt),
                .blk_o     (tx_blk),
                .err_o     (tx_err)
            );
        end else begin : g_tx_byp
            logic [BLK_W-1:0] byp_d, byp_q;
            always_comb byp_d = {HDR_DATA, tx_data};
            always_ff @(posedge clk) begin
                if (rst) byp_q <= {HDR_DATA, {WORD_W{1'b0}}};
                else     byp_q <= byp_d;
            end
            assign tx_blk = byp_q;
            assign tx_err = '0;
        end

        if (RX_DEC_EN) begin : g_rx
            blk66_rx_dec u_rx (
                .clk        (clk),
                .rst        (rst),
                .blk_i      (rx_blk),
                .ber_high_i (rx_ber_high),
                .data_o     (rx_data),
                .ctrl_o     (rx_ctrl),
                .err_o      (rx_err)
            );
        end else begin : g_rx_byp
            logic [WORD_W-1:0] byp_d, byp_q;
            always_comb byp_d = rx_blk[WORD_W-1:0];
            always_ff @(posedge clk) begin
                if (rst) byp_q <= '0;
                else     byp_q <= byp_d;
            end
            assign rx_data = byp_q;
            assign rx_ctrl = '0;
            assign rx_err  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/blk66_codec_chk.sv
module blk66_codec_chk
    import blk66_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_hdr_corrupt,
    input logic [BLK_W-1:0]  tx_blk,
    input logic [ERR_W-1:0]  tx_err,
    input logic [BLK_W-1:0]  rx_blk,
    input logic              rx_ber_high,
    input logic [WORD_W-1:0] rx_data,
    input logic [LANES-1:0]  rx_ctrl,
    input logic              rx_err
);

    // R5: without the corrupt request the header is always one of the two legal values
    p_hdr_legal_r5: assert property (@(posedge clk) disable iff (rst)
        !tx_hdr_corrupt |=> (tx_blk[BLK_W-1] ^ tx_blk[BLK_W-2]));

    // R3 / R4: an ordering or pattern error always carries the error block payload
    p_err_blk_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_err[ERR_SEQ] || tx_err[ERR_PAT]) |->
            (tx_blk[WORD_W-1:0] == err_payload() && tx_blk[BLK_W-1]));

    // R9: a raised error-rate status forces error output on the next cycle
    p_ber_force_r9: assert property (@(posedge clk) disable iff (rst)
        rx_ber_high |=> rx_err);

    // R7: an invalid received header yields error output on the next cycle
    p_bad_hdr_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_blk[BLK_W-1] == rx_blk[BLK_W-2]) |=> rx_err);

    // R7: error output always means error characters with every flag set
    p_err_word_r7: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (rx_ctrl == '1 && rx_data == fill_word(CH_ERR)));

endmodule

bind blk66_codec blk66_codec_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_hdr_corrupt (tx_hdr_corrupt),
    .tx_blk         (tx_blk),
    .tx_err         (tx_err),
    .rx_blk         (rx_blk),
    .rx_ber_high    (rx_ber_high),
    .rx_data        (rx_data),
    .rx_ctrl        (rx_ctrl),
    .rx_err         (rx_err)
);

// File: tb/blk66_codec_test.sv
`timescale 1ns/1ps
module blk66_codec_test;

    localparam logic [65:0] IDLE_BLK = {2'b10, 56'h0, 8'h1E};
    localparam logic [65:0] ERR_BLK  = {2'b10, {8{7'h1E}}, 8'h1E};
    localparam logic [63:0] IDLE_W   = {8{8'h07}};
    localparam logic [63:0] ERR_W    = {8{8'hFE}};
    localparam logic [63:0] START_W  = 64'h01020304050607FB;
    localparam logic [65:0] START_B  = {2'b10, 56'h01020304050607, 8'h78};
    localparam logic [63:0] DATA_W   = 64'hDEADBEEF01234567;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tx_data = IDLE_W;
    logic [7:0]  tx_ctrl = 8'hFF;
    logic        tx_hdr_corrupt = 1'b0;
    logic [65:0] tx_blk;
    logic [2:0]  tx_err;
    logic [65:0] rx_blk = IDLE_BLK;
    logic        rx_ber_high = 1'b0;
    logic [63:0] rx_data;
    logic [7:0]  rx_ctrl;
    logic        rx_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    blk66_codec uut (
        .clk            (clk),
        .rst            (rst),
        .tx_data        (tx_data),
        .tx_ctrl        (tx_ctrl),
        .tx_hdr_corrupt (tx_hdr_corrupt),
        .tx_blk         (tx_blk),
        .tx_err         (tx_err),
        .rx_blk         (rx_blk),
        .rx_ber_high    (rx_ber_high),
        .rx_data        (rx_data),
        .rx_ctrl        (rx_ctrl),
        .rx_err         (rx_err)
    );

    task automatic tx_step(input logic [63:0] d, input logic [7:0] c, input logic inj,
                           input logic [65:0] eb, input logic [2:0] ee, input string tag);
        tx_data = d; tx_ctrl = c; tx_hdr_corrupt = inj;
        rx_blk = IDLE_BLK; rx_ber_high = 1'b0;
        @(negedge clk);
        checks++;
        if (tx_blk !== eb || tx_err !== ee) begin
            fails++;
            $display("FAIL %s: blk=%h err=%b expected blk=%h err=%b", tag, tx_blk, tx_err, eb, ee);
        end
    endtask

    task automatic rx_step(input logic [65:0] b, input logic ber,
                           input logic [63:0] ed, input logic [7:0] ec, input logic ee,
                           input string tag);
        rx_blk = b; rx_ber_high = ber;
        tx_data = IDLE_W; tx_ctrl = 8'hFF; tx_hdr_corrupt = 1'b0;
        @(negedge clk);
        checks++;
        if (rx_data !== ed || rx_ctrl !== ec || rx_err !== ee) begin
            fails++;
            $display("FAIL %s: data=%h ctrl=%h err=%b expected data=%h ctrl=%h err=%b",
                     tag, rx_data, rx_ctrl, rx_err, ed, ec, ee);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (tx_blk !== IDLE_BLK || tx_err !== 3'b000) begin
            fails++;
            $display("FAIL R10 tx reset: blk=%h err=%b expected blk=%h err=000", tx_blk, tx_err, IDLE_BLK);
        end
        checks++;
        if (rx_data !== IDLE_W || rx_ctrl !== 8'hFF || rx_err !== 1'b0) begin
            fails++;
            $display("FAIL R10 rx reset: data=%h ctrl=%h err=%b expected data=%h ctrl=ff err=0",
                     rx_data, rx_ctrl, rx_err, IDLE_W);
        end
        rst = 1'b0;
        tx_data = DATA_W; tx_ctrl = 8'h00;
        rx_blk = {2'b01, DATA_W};
        @(negedge clk);
        checks++;
        if (tx_blk !== ERR_BLK || tx_err !== 3'b001) begin
            fails++;
            $display("FAIL R10 tx first data: blk=%h err=%b expected blk=%h err=001", tx_blk, tx_err, ERR_BLK);
        end
        checks++;
        if (rx_err !== 1'b1 || rx_data !== ERR_W) begin
            fails++;
            $display("FAIL R10 rx first data: data=%h err=%b expected data=%h err=1", rx_data, rx_err, ERR_W);
        end
    endtask

    task automatic t_tx_frames();
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R2 idle");
        tx_step(START_W, 8'h01, 1'b0, START_B, 3'b000, "R2 start");
        tx_step(DATA_W, 8'h00, 1'b0, {2'b01, DATA_W}, 3'b000, "R1 data");
        tx_step(64'h07070707FDCCBBAA, 8'hF8, 1'b0, {2'b10, 32'h0, 24'hCCBBAA, 8'hB4}, 3'b000, "R2 term lane3");
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R2 idle after term");
        tx_step(START_W, 8'h01, 1'b0, START_B, 3'b000, "R2 start");
        tx_step(64'h07070707070707FD, 8'hFF, 1'b0, {2'b10, 56'h0, 8'h87}, 3'b000, "R2 term lane0");
        tx_step(START_W, 8'h01, 1'b0, START_B, 3'b000, "R2 start");
        tx_step(64'h0011223344556677, 8'h00, 1'b0, {2'b01, 64'h0011223344556677}, 3'b000, "R1 data2");
        tx_step(64'hFD77767574737271, 8'h80, 1'b0, {2'b10, 56'h77767574737271, 8'hFF}, 3'b000, "R2 term lane7");
    endtask

    task automatic t_tx_order();
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R3 sync idle");
        tx_step(DATA_W, 8'h00, 1'b0, ERR_BLK, 3'b001, "R3 data after idle");
        tx_step(DATA_W, 8'h00, 1'b0, ERR_BLK, 3'b001, "R3 error persists");
        tx_step(64'h07070707070707FD, 8'hFF, 1'b0, ERR_BLK, 3'b001, "R3 term in error");
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R3 idle resyncs");
        tx_step(START_W, 8'h01, 1'b0, START_B, 3'b000, "R3 start");
        tx_step(START_W, 8'h01, 1'b0, ERR_BLK, 3'b001, "R3 start after start");
        tx_step(DATA_W, 8'h00, 1'b0, ERR_BLK, 3'b001, "R3 data in error");
        tx_step(START_W, 8'h01, 1'b0, START_B, 3'b000, "R3 start resyncs");
        tx_step(64'h07070707070707FD, 8'hFF, 1'b0, {2'b10, 56'h0, 8'h87}, 3'b000, "R3 term legal");
    endtask

    task automatic t_tx_pattern();
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R4 sync idle");
        tx_step(64'h0123456789ABCDEF, 8'h0F, 1'b0, ERR_BLK, 3'b010, "R4 unknown pattern");
        tx_step(64'h070707070707FB07, 8'hFF, 1'b0, ERR_BLK, 3'b010, "R4 stray start char");
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R4 idle recovers");
    endtask

    task automatic t_tx_inject();
        tx_step(IDLE_W, 8'hFF, 1'b1, {2'b11, 56'h0, 8'h1E}, 3'b100, "R5 idle corrupt");
        tx_step(START_W, 8'h01, 1'b1, {2'b11, 56'h01020304050607, 8'h78}, 3'b100, "R5 start corrupt");
        tx_step(DATA_W, 8'h00, 1'b1, {2'b00, DATA_W}, 3'b100, "R5 data corrupt");
        tx_step(64'h07070707070707FD, 8'hFF, 1'b0, {2'b10, 56'h0, 8'h87}, 3'b000, "R5 term clean");
        tx_step(DATA_W, 8'h00, 1'b1, {2'b11, {8{7'h1E}}, 8'h1E}, 3'b101, "R5 R3 corrupt with order error");
        tx_step(IDLE_W, 8'hFF, 1'b0, IDLE_BLK, 3'b000, "R5 clean idle");
    endtask

    task automatic t_rx_decode();
        rx_step(IDLE_BLK, 1'b0, IDLE_W, 8'hFF, 1'b0, "R6 idle");
        rx_step({2'b10, 56'hA1A2A3A4A5A6A7, 8'h78}, 1'b0, 64'hA1A2A3A4A5A6A7FB, 8'h01, 1'b0, "R6 start");
        rx_step({2'b01, DATA_W}, 1'b0, DATA_W, 8'h00, 1'b0, "R6 data");
        rx_step({2'b10, 40'h0, 16'h2211, 8'hAA}, 1'b0, 64'h0707070707FD2211, 8'hFC, 1'b0, "R6 term lane2");
        rx_step({2'b10, 56'hA1A2A3A4A5A6A7, 8'h78}, 1'b0, 64'hA1A2A3A4A5A6A7FB, 8'h01, 1'b0, "R6 start");
        rx_step({2'b10, 56'hF7F6F5F4F3F2F1, 8'hFF}, 1'b0, 64'hFDF7F6F5F4F3F2F1, 8'h80, 1'b0, "R6 term lane7");
    endtask

    task automatic t_rx_bad();
        rx_step({2'b00, DATA_W}, 1'b0, ERR_W, 8'hFF, 1'b1, "R7 header 00");
        rx_step(IDLE_BLK, 1'b0, IDLE_W, 8'hFF, 1'b0, "R7 idle recovers");
        rx_step({2'b11, 56'h0, 8'h1E}, 1'b0, ERR_W, 8'hFF, 1'b1, "R7 header 11");
        rx_step({2'b10, 56'h0, 8'h55}, 1'b0, ERR_W, 8'hFF, 1'b1, "R7 unknown type");
        rx_step(IDLE_BLK, 1'b0, IDLE_W, 8'hFF, 1'b0, "R7 idle recovers again");
    endtask

    task automatic t_rx_order();
        rx_step({2'b01, DATA_W}, 1'b0, ERR_W, 8'hFF, 1'b1, "R8 data after idle");
        rx_step({2'b10, 56'h0, 8'h87}, 1'b0, ERR_W, 8'hFF, 1'b1, "R8 term in error");
        rx_step({2'b10, 56'hA1A2A3A4A5A6A7, 8'h78}, 1'b0, 64'hA1A2A3A4A5A6A7FB, 8'h01, 1'b0, "R8 start resyncs");
        rx_step({2'b10, 56'hA1A2A3A4A5A6A7, 8'h78}, 1'b0, ERR_W, 8'hFF, 1'b1, "R8 start after start");
        rx_step(IDLE_BLK, 1'b0, IDLE_W, 8'hFF, 1'b0, "R8 idle resyncs");
    endtask

    task automatic t_rx_ber();
        rx_step({2'b10, 56'hA1A2A3A4A5A6A7, 8'h78}, 1'b0, 64'hA1A2A3A4A5A6A7FB, 8'h01, 1'b0, "R9 start");
        rx_step({2'b01, DATA_W}, 1'b1, ERR_W, 8'hFF, 1'b1, "R9 ber on legal data");
        rx_step(IDLE_BLK, 1'b1, ERR_W, 8'hFF, 1'b1, "R9 ber on idle");
        rx_step({2'b01, DATA_W}, 1'b0, ERR_W, 8'hFF, 1'b1, "R9 data after ber drop");
        rx_step(IDLE_BLK, 1'b0, IDLE_W, 8'hFF, 1'b0, "R9 idle recovers");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_tx_frames();
        t_tx_order();
        t_tx_pattern();
        t_tx_inject();
        t_rx_decode();
        t_rx_bad();
        t_rx_order();
        t_rx_ber();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule